// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block is the host-side engine for a single-channel serial voltage-output DAC that listens on a three-wire, write-only interface made of chip select, serial clock and serial data. A client hands it one request at a time on a valid/ready handshake. Each request carries a command, a DAC code and a power-down mode. The block builds the frame for that command, shifts it out MSB first from the system clock, and leaves chip select high for a minimum time before the next frame can start. It pulses `done` when a frame closes.

Two frame formats are supported, selected by a parameter. The narrow form has 16 bits and a 14-bit code. The wide form has 24 bits and a 16-bit code. The device takes each bit on the falling edge of the serial clock. The block therefore changes data only on rising edges, which gives half a serial-clock period of setup and half a period of hold around every falling edge. The serial-clock half period and the minimum chip-select high time are parameters counted in system clock cycles. With the defaults and a 250 MHz system clock, the serial clock runs at about 41.7 MHz and chip select stays high for at least 20 ns.

Top module: `sdac_host_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `dac_cs_n` is 1, `dac_sclk` is 1, `dac_sdo` is 0, `done` is 0 and `req_ready` is 1.
- R2: An accepted request produces exactly FRAME_W falling edges of `dac_sclk` while `dac_cs_n` is low (24 in the wide form, 16 in the narrow form), with the frame's most significant bit first.
- R3: `req_cmd` 2'b01 (write-through) sends the leading bits 0 then 1, followed by `req_code`. In the wide form the code occupies frame bits 21..0 down to 6. In the narrow form it occupies bits 13..0. All remaining bits are 0.
- R4: `req_cmd` 2'b10 (power-down) sends the leading bits 1 then 0. `req_pd_mode` goes in frame bits 19..18 (wide) or 11..10 (narrow). The code is ignored, and every other bit is 0.
- R5: `req_cmd` 2'b00 (no-op) and the unused value 2'b11 both send an all-zero frame, whatever the code and mode inputs hold.
- R6: While `dac_cs_n` is low, `dac_sdo` changes only in the cycle in which `dac_sclk` rises. Every low phase of `dac_sclk` lasts exactly HALF_DIV system cycles.
- R7: `dac_cs_n` falls in the cycle after acceptance, with `dac_sclk` high. The first falling edge of `dac_sclk` comes HALF_DIV cycles later.
- R8: After `dac_cs_n` rises, `req_ready` returns after exactly GAP_CYC cycles. `dac_cs_n` is high for at least GAP_CYC+1 cycles between any two frames.
- R9: `req_ready` is low from the cycle after acceptance until the gap has ended. `req_valid` asserted while `req_ready` is low starts no frame and does not alter the frame in flight.
- R10: `done` is high for exactly one cycle: the cycle in which `dac_cs_n` has just risen at the end of a frame.
- R11: `dac_sclk` is high whenever `dac_cs_n` is high.
- R12: Taking `rst_n` low in the middle of a frame ends it at once. `dac_cs_n` goes high, no `done` pulse follows, and `req_ready` is 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_cmd | input | 2 | 00 no-op, 01 write-through, 10 power-down, 11 treated as no-op |
| req_pd_mode | input | 2 | Power-down mode field |
| req_code | input | CODE_W (16 by default) | DAC code for write-through |
| dac_cs_n | output | 1 | Active-low chip select to the DAC |
| dac_sclk | output | 1 | Serial clock to the DAC, idles high |
| dac_sdo | output | 1 | Serial data to the DAC |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
Every output is registered. Acceptance happens at the edge where `req_valid` and `req_ready` are both high. `dac_cs_n` falls and `req_ready` drops at that same edge. The first serial-clock fall comes HALF_DIV edges later, and each clock phase lasts HALF_DIV edges after that. `dac_cs_n` rises together with `done` at the edge that ends the last high phase, and `req_ready` returns GAP_CYC edges after that. The bench samples on the falling system-clock edge. It counts samples from the first sample after acceptance and from the first sample after chip select rises, and compares those run lengths and the captured bits against the figures above.

// File: rtl/sdac_host_pkg.sv
// Package: shared command encoding and sequencer states for the serial DAC host.
// Assumes: the command value equals the two leading bits that the frame carries.
package sdac_host_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_PDOWN = 2'b10,
        CMD_RSVD  = 2'b11
    } sdac_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_GAP  = 3'd4
    } sdac_state_e;

endpackage

// File: rtl/sdac_frame_build.sv
// Module: assembles the serial frame for one request.
// Frame length and code width follow WIDE_FRAME. Every unused position is zero.
// The unused command value is sent as an all-zero no-op frame.
// Assumes: inputs are stable in the cycle in which the frame is loaded.
module sdac_frame_build
    import sdac_host_pkg::*;
#(
    parameter int WIDE_FRAME = 1,
    localparam int FRAME_W   = (WIDE_FRAME != 0) ? 24 : 16,
    localparam int CODE_W    = (WIDE_FRAME != 0) ? 16 : 14
) (
    input  logic [1:0]         cmd,
    input  logic [1:0]         pd_mode,
    input  logic [CODE_W-1:0]  code,
    output logic [FRAME_W-1:0] frame
);

    localparam int CODE_LO = FRAME_W - 2 - CODE_W;
    localparam int MODE_HI = FRAME_W - 5;

    sdac_cmd_e cmd_e;
    logic [FRAME_W-1:0] code_field;

    assign cmd_e = sdac_cmd_e'(cmd);

    // Place the code at its position; the padding below it depends on the format.
    generate
        if (CODE_LO > 0) begin : g_padded
            assign code_field = {2'b00, code, {CODE_LO{1'b0}}};
        end else begin : g_flush
            assign code_field = {2'b00, code};
        end
    endgenerate

    // Select the field layout from the command.
    always_comb begin
        frame = '0;
        unique case (cmd_e)
            CMD_WRITE: begin
                frame = code_field;
                frame[FRAME_W-1 -: 2] = 2'b01;
            end
            CMD_PDOWN: begin
                frame[FRAME_W-1 -: 2] = 2'b10;
                frame[MODE_HI -: 2]   = pd_mode;
            end
            default: frame = '0;
        endcase
    end

endmodule

// File: rtl/sdac_phase_timer.sv
// Module: a down-counter shared by the lead, clock-phase and gap intervals.
// After a load of value N, expired is high N system cycles later.
// Assumes: load and load_val are driven by the sequencer in the same cycle.
module sdac_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_shift_out.sv
// Module: parallel-load shift register, MSB first, that drives the serial data line.
// Clear has priority, then load, then shift. Zeros shift in from the bottom.
// Assumes: the sequencer never asserts load and shift together.
module sdac_shift_out #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               sdo
);

    logic [FRAME_W-1:0] sh_q;

    // Hold the frame and move the next bit to the top on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= frame_in;
        end else if (shift) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo = sh_q[FRAME_W-1];

endmodule

// File: rtl/sdac_seq.sv
// Module: frame sequencer. It owns chip select, serial clock, ready and done.
// Timing: chip select falls with the clock high. After HALF_DIV cycles come
// FRAME_W low/high clock periods of 2*HALF_DIV cycles. Data moves on each rising
// edge. Chip select then rises and the block waits GAP_CYC cycles before ready returns.
// Assumes: HALF_DIV >= 1 and GAP_CYC >= 1; timer values fit in CNT_W bits.
module sdac_seq
    import sdac_host_pkg::*;
#(
    parameter int FRAME_W  = 24,
    parameter int HALF_DIV = 3,
    parameter int GAP_CYC  = 5,
    parameter int CNT_W    = 4,
    localparam int BIT_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_shift,
    output logic             sh_clear,
    output logic             cs_n,
    output logic             sclk,
    output logic             done
);

    localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

    sdac_state_e      state_q;
    logic [BIT_W-1:0] bits_left_q;
    logic             accept;
    logic             phase_end;
    logic             last_bit;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign phase_end = tmr_expired && (state_q != ST_IDLE);
    assign last_bit  = (bits_left_q == '0);

    // Timer and shift-register controls decoded from the state and the timer.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = HALF_LOAD;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load = accept;
                sh_load  = accept;
            end
            ST_LEAD: tmr_load = phase_end;
            ST_LOW: begin
                tmr_load = phase_end;
                sh_shift = phase_end && !last_bit;
            end
            ST_HIGH: begin
                tmr_load = phase_end;
                if (last_bit) begin
                    tmr_val  = GAP_LOAD;
                    sh_clear = phase_end;
                end
            end
            ST_GAP:  tmr_load = 1'b0;
            default: tmr_load = 1'b0;
        endcase
    end

    // State, bit count and registered interface lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
            cs_n        <= 1'b1;
            sclk        <= 1'b1;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q     <= ST_LEAD;
                        bits_left_q <= LAST_BIT;
                        cs_n        <= 1'b0;
                        sclk        <= 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (phase_end) begin
                        state_q <= ST_LOW;
                        sclk    <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        state_q <= ST_HIGH;
                        sclk    <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        if (last_bit) begin
                            state_q <= ST_GAP;
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            state_q     <= ST_LOW;
                            sclk        <= 1'b0;
                            bits_left_q <= bits_left_q - 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdac_host_ctrl.sv
// Module: top of the serial DAC host write controller.
// It ties together the frame builder, the shared phase timer, the output shift
// register and the sequencer. A request is taken when req_valid and req_ready are both high.
// Assumes: the system clock divided by 2*HALF_DIV stays within the device's serial-clock
// limit, and GAP_CYC system cycles cover the device's minimum chip-select high time.
module sdac_host_ctrl
    import sdac_host_pkg::*;
#(
    parameter int WIDE_FRAME = 1,
    parameter int HALF_DIV   = 3,
    parameter int GAP_CYC    = 5,
    localparam int FRAME_W   = (WIDE_FRAME != 0) ? 24 : 16,
    localparam int CODE_W    = (WIDE_FRAME != 0) ? 16 : 14,
    localparam int CNT_MAX   = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [1:0]        req_pd_mode,
    input  logic [CODE_W-1:0] req_code,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              done
);

    logic [FRAME_W-1:0] frame;
    logic               tmr_expired;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               sh_load;
    logic               sh_shift;
    logic               sh_clear;

    sdac_frame_build #(
        .WIDE_FRAME (WIDE_FRAME)
    ) u_build (
        .cmd     (req_cmd),
        .pd_mode (req_pd_mode),
        .code    (req_code),
        .frame   (frame)
    );

    sdac_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdac_shift_out #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .load     (sh_load),
        .shift    (sh_shift),
        .frame_in (frame),
        .sdo      (dac_sdo)
    );

    sdac_seq #(
        .FRAME_W  (FRAME_W),
        .HALF_DIV (HALF_DIV),
        .GAP_CYC  (GAP_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sh_load     (sh_load),
        .sh_shift    (sh_shift),
        .sh_clear    (sh_clear),
        .cs_n        (dac_cs_n),
        .sclk        (dac_sclk),
        .done        (done)
    );

endmodule

// File: rtl/sdac_host_chk.sv
// Module: protocol checker for the serial DAC host, bound to the top module.
// It watches only the top-level ports. A saturating counter measures chip-select high time.
module sdac_host_chk #(
    parameter int GAP_CYC = 5,
    localparam int GW     = $clog2(GAP_CYC + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic dac_cs_n,
    input logic dac_sclk,
    input logic dac_sdo,
    input logic done
);

    localparam logic [GW-1:0] GAP_SAT = GW'(GAP_CYC + 1);

    logic [GW-1:0] hi_cnt_q;

    // Count cycles with chip select high, saturating; reset counts as a long gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= GAP_SAT;
        end else if (!dac_cs_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != GAP_SAT) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    // R6
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n) && !$rose(dac_sclk)) |-> $stable(dac_sdo));

    // R11
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> dac_sclk);

    // R10
    done_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(dac_cs_n));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    start_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> $past(req_valid && req_ready));

    // R8
    cs_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (hi_cnt_q >= GW'(GAP_CYC)));

endmodule

bind sdac_host_ctrl sdac_host_chk #(
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dac_cs_n  (dac_cs_n),
    .dac_sclk  (dac_sclk),
    .dac_sdo   (dac_sdo),
    .done      (done)
);

// File: tb/sdac_host_ctrl_bench.sv
// Bench for the serial DAC host write controller, wide (24-bit) frame form.
module sdac_host_ctrl_bench;

    localparam int HALF_DIV = 3;
    localparam int GAP_CYC  = 5;
    localparam int FRAME_W  = 24;
    localparam int NVEC     = 10;

    // {cmd, pd_mode, code, expected frame}
    localparam logic [43:0] VECS [NVEC] = '{
        {2'b01, 2'b00, 16'hA5C3, 24'h6970C0},
        {2'b01, 2'b11, 16'hFFFF, 24'h7FFFC0},
        {2'b01, 2'b00, 16'h0000, 24'h400000},
        {2'b01, 2'b00, 16'h8000, 24'h600000},
        {2'b10, 2'b11, 16'hFFFF, 24'h8C0000},
        {2'b10, 2'b01, 16'h0000, 24'h840000},
        {2'b10, 2'b10, 16'h5555, 24'h880000},
        {2'b10, 2'b00, 16'hFFFF, 24'h800000},
        {2'b00, 2'b11, 16'h1234, 24'h000000},
        {2'b11, 2'b11, 16'hFFFF, 24'h000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cmd = 2'b00;
    logic [1:0]  req_pd_mode = 2'b00;
    logic [15:0] req_code = 16'h0000;
    logic        dac_cs_n;
    logic        dac_sclk;
    logic        dac_sdo;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sdac_host_ctrl #(
        .WIDE_FRAME (1),
        .HALF_DIV   (HALF_DIV),
        .GAP_CYC    (GAP_CYC)
    ) u_sdac_host_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cmd     (req_cmd),
        .req_pd_mode (req_pd_mode),
        .req_code    (req_code),
        .dac_cs_n    (dac_cs_n),
        .dac_sclk    (dac_sclk),
        .dac_sdo     (dac_sdo),
        .done        (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Send one request and follow the frame at the pins until ready returns.
    task automatic run_frame(input logic [1:0] cmd, input logic [1:0] mode,
                             input logic [15:0] code, input logic [23:0] exp,
                             input bit poke);
        logic [FRAME_W-1:0] cap = '0;
        int lead = 0, falls = 0, low_run = 0, bad_low = 0, bad_sdo = 0, gap = 0;
        int guard = 0;
        logic prev_sclk, prev_sdo;
        string tag;
        tag = (cmd == 2'b01) ? "R3" : (cmd == 2'b10) ? "R4" : "R5";
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_pd_mode = mode; req_code = code;
        @(negedge clk);
        req_valid = 1'b0;
        // R7 / R9: chip select low and ready low in the first sample after acceptance
        chk(!dac_cs_n && dac_sclk, "R7", "cs low with sclk high after accept", {dac_cs_n, dac_sclk}, 2'b01);
        chk(!req_ready, "R9", "ready low after accept", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_cmd = 2'b01; req_code = 16'h0F0F;
        end
        prev_sclk = 1'b1;
        prev_sdo  = dac_sdo;
        while (!dac_cs_n && guard < 1000) begin
            if (dac_sclk && falls == 0) lead++;
            if (!dac_sclk) low_run++;
            if (prev_sclk && !dac_sclk) begin
                falls++;
                cap = {cap[FRAME_W-2:0], dac_sdo};
            end
            if (!prev_sclk && dac_sclk) begin
                if (low_run != HALF_DIV) bad_low++;
                low_run = 0;
            end
            if (dac_sdo != prev_sdo && !(!prev_sclk && dac_sclk)) bad_sdo++;
            prev_sclk = dac_sclk;
            prev_sdo  = dac_sdo;
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(cap == exp, tag, "captured frame", 32'(cap), 32'(exp));
        chk(falls == FRAME_W, "R2", "falling edges per frame", falls, FRAME_W);
        chk(lead == HALF_DIV, "R7", "lead cycles before first fall", lead, HALF_DIV);
        chk(bad_low == 0 && bad_sdo == 0, "R6", "bad low phases / early data moves",
            32'(bad_low * 256 + bad_sdo), 0);
        chk(done, "R10", "done at chip select rise", done, 1);
        while (!req_ready && gap < 100) begin
            gap++;
            @(negedge clk);
            if (!req_ready) begin
                chk(!done && dac_cs_n && dac_sclk, "R11", "idle lines during gap",
                    {done, dac_cs_n, dac_sclk}, 3'b011);
            end
        end
        chk(gap == GAP_CYC, "R8", "cycles until ready returns", gap, GAP_CYC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(dac_cs_n && dac_sclk && !dac_sdo && !done && req_ready, "R1", "lines in reset",
            {dac_cs_n, dac_sclk, dac_sdo, done, req_ready}, 5'b11001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dac_cs_n && dac_sclk && !dac_sdo && !done && req_ready, "R1", "lines after reset",
            {dac_cs_n, dac_sclk, dac_sdo, done, req_ready}, 5'b11001);

        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i][43:42], VECS[i][41:40], VECS[i][39:24], VECS[i][23:0], 1'b0);
        end

        // R9: a request held during a busy frame leaves that frame intact and starts nothing
        run_frame(2'b01, 2'b00, 16'h1357, 24'h44D5C0, 1'b1);
        repeat (10) @(negedge clk);
        chk(dac_cs_n && req_ready, "R9", "no frame from request made while busy",
            {dac_cs_n, req_ready}, 2'b11);

        // R8: back-to-back requests still respect the gap
        run_frame(2'b10, 2'b01, 16'h0000, 24'h840000, 1'b0);
        run_frame(2'b01, 2'b00, 16'h0001, 24'h400040, 1'b0);

        // R12: reset in the middle of a frame
        req_valid = 1'b1; req_cmd = 2'b01; req_code = 16'hFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(!dac_cs_n, "R12", "frame in flight before reset", dac_cs_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_cs_n && dac_sclk && !done, "R12", "lines right after mid-frame reset",
            {dac_cs_n, dac_sclk, done}, 3'b110);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(dac_cs_n && !done && req_ready, "R12", "idle after release",
                {dac_cs_n, done, req_ready}, 3'b101);
        end

        // Ensure normal operation after the abort
        run_frame(2'b01, 2'b00, 16'hA5C3, 24'h6970C0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule